// File: doc/BRIEF.md
# Frame-Clock Ratio Detector

The block sits on a bit clock that is known to be synchronous to an 8 kHz frame-sync signal. It counts how many bit-clock cycles separate two rising edges of frame sync, compares the count against the eight clock-per-frame ratios the system supports, and turns a match into a 3-bit multiplier code. Downstream clock synthesis uses that code to pick the multiplication that reaches its internal rate.

The code is captured once after each reset. A count is accepted only when two back-to-back frames measure the same supported value. From then on the outputs are frozen and the valid flag stays high until the next reset. A count that fits no supported ratio raises an error flag. In that case the code stays at its reset value.

Top module: `fcr_ratio_detect`

## Requirements
- R1: While reset is asserted (`rst_n` low at a clock edge) and on the first cycle after it, `mult_code` is 0, `code_valid` is 0 and `ratio_err` is 0.
- R2: The code is assigned in rising ratio order: 32 cycles per frame gives 0, 64 gives 1, 96 gives 2, 128 gives 3, 192 gives 4, 256 gives 5, 512 gives 6 and 1024 gives 7.
- R3: A period is the number of bit-clock cycles from one rising edge of `fsync` to the next. The interval from reset release to the first rising edge is never measured, so three rising edges are needed before a lock.
- R4: `code_valid` rises only after two consecutive measured periods are equal and supported. Once high, it stays high until reset.
- R5: After `code_valid` is high, later frames of any length leave `mult_code`, `code_valid` and `ratio_err` unchanged.
- R6: Before lock, a measured period that matches no supported ratio sets `ratio_err`. `mult_code` stays 0 and `code_valid` stays 0 whenever no lock has occurred.
- R7: Before lock, a measured period that is supported clears `ratio_err`. `ratio_err` is never high together with `code_valid`.
- R8: Only the low-to-high transition of `fsync` marks a frame. A pulse of `fsync` that stays high for several cycles counts as one edge.
- R9: The period counter saturates at its maximum (4095 with default parameters) and does not wrap. A period longer than that is treated as unsupported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, synchronous to `clk` |
| mult_code | output | 3 | Latched multiplier code |
| code_valid | output | 1 | High once a code has been committed |
| ratio_err | output | 1 | High when the last pre-lock period was unsupported |

## Verification
The hardest situations to reach are the ones where a lock must not happen. Two frames of different supported lengths must not commit a code. The partial interval before the first edge must not be counted, even when it has exactly a supported length. The bench drives a supported-length idle gap before the first edge and alternates 64 and 128 cycle frames. It also sweeps every period from 20 to 140 plus each supported ratio and its two neighbours, so near-miss counts are shown to flag an error rather than lock. A frame longer than the counter range checks that saturation does not alias onto a supported value.

// File: rtl/fcr_pkg.sv
// Package: shared constants and the ratio table for the frame-clock ratio detector.
// Assumes eight supported ratios derived from one base ratio.
package fcr_pkg;
    localparam int NUM_RATIOS = 8;
    localparam int CODE_W     = 3;

    // Ratio for a given code index: base * {1,2,3,4,6,8,16,32}
    function automatic int ratio_of(input int idx, input int base);
        if (idx < 4)
            return base * (idx + 1);
        else if (idx < 6)
            return 2 * base * (idx - 1);
        else
            return base << (idx - 2);
    endfunction
endpackage

// File: rtl/fcr_edge_count.sv
// Module: detects rising edges of frame sync and measures the period between them.
// Assumes fsync is synchronous to clk. The first edge after reset only arms the counter.
module fcr_edge_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             meas_stb,
    output logic [CNT_W-1:0] meas_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             fs_q;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             rise;

    // Rising edge of frame sync against its previous sample
    assign rise = fsync && !fs_q;

    // Frame-sync history, arming flag and saturating period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= 1'b0;
            armed <= 1'b0;
            cnt   <= '0;
        end else begin
            fs_q <= fsync;
            if (rise) begin
                armed <= 1'b1;
                cnt   <= CNT_W'(1);
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // A completed period is reported only after the counter has been armed
    assign meas_stb = rise && armed;
    assign meas_cnt = cnt;

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !rise) |=> (cnt == CNT_MAX)); // R9
    AST_FIRST_EDGE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !armed) |-> !meas_stb); // R3
endmodule

// File: rtl/fcr_classify.sv
// Module: maps a measured period onto one of the supported ratios.
// Assumes codes ascend with ratio. Combinational only.
module fcr_classify
    import fcr_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int BASE  = 32
) (
    input  logic [CNT_W-1:0]  meas_cnt,
    output logic              supported,
    output logic [CODE_W-1:0] code
);
    logic [NUM_RATIOS-1:0] hit;

    // One comparator per supported ratio
    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_cmp
        localparam logic [CNT_W-1:0] RATIO = CNT_W'(ratio_of(g, BASE));
        assign hit[g] = (meas_cnt == RATIO);
    end

    // Encode the single hit into its code
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_RATIOS; i++)
            if (hit[i]) code = CODE_W'(i);
    end

    assign supported = |hit;

    always_comb begin
        AST_ONE_HIT: assert ($onehot0(hit)); // R2
    end
endmodule

// File: rtl/fcr_lock.sv
// Module: commits the code after two equal supported periods in a row, then freezes.
// Assumes one measurement strobe per frame.
module fcr_lock
    import fcr_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_stb,
    input  logic [CNT_W-1:0]  meas_cnt,
    input  logic              supported,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] mult_code,
    output logic              code_valid,
    output logic              ratio_err
);
    logic [CNT_W-1:0] prev_cnt;
    logic             have_prev;

    // Match tracking, error flag and one-shot commit of the multiplier code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cnt   <= '0;
            have_prev  <= 1'b0;
            mult_code  <= '0;
            code_valid <= 1'b0;
            ratio_err  <= 1'b0;
        end else if (meas_stb && !code_valid) begin
            if (!supported) begin
                ratio_err <= 1'b1;
                have_prev <= 1'b0;
            end else begin
                ratio_err <= 1'b0;
                have_prev <= 1'b1;
                prev_cnt  <= meas_cnt;
                if (have_prev && prev_cnt == meas_cnt) begin
                    mult_code  <= code_in;
                    code_valid <= 1'b1;
                end
            end
        end
    end

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> code_valid); // R4
    AST_LOCK_ON_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> $past(meas_stb && supported)); // R4
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> ($stable(mult_code) && $stable(ratio_err))); // R5
    AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> (mult_code == '0)); // R6
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_valid && ratio_err)); // R7
endmodule

// File: rtl/fcr_ratio_detect.sv
// Module: top of the frame-clock ratio detector.
// Measures bit-clock cycles per frame, classifies the count and latches a 3-bit code once after reset.
// Assumes fsync is synchronous to clk and rst_n is synchronous active-low.
module fcr_ratio_detect
    import fcr_pkg::*;
#(
    parameter int BASE  = 32,
    parameter int CNT_W = $clog2(BASE * 32) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    output logic [CODE_W-1:0] mult_code,
    output logic              code_valid,
    output logic              ratio_err
);
    logic              meas_stb;
    logic [CNT_W-1:0]  meas_cnt;
    logic              supported;
    logic [CODE_W-1:0] code_c;

    fcr_edge_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .meas_stb (meas_stb),
        .meas_cnt (meas_cnt)
    );

    fcr_classify #(.CNT_W(CNT_W), .BASE(BASE)) u_cls (
        .meas_cnt  (meas_cnt),
        .supported (supported),
        .code      (code_c)
    );

    fcr_lock #(.CNT_W(CNT_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_stb   (meas_stb),
        .meas_cnt   (meas_cnt),
        .supported  (supported),
        .code_in    (code_c),
        .mult_code  (mult_code),
        .code_valid (code_valid),
        .ratio_err  (ratio_err)
    );
endmodule

// File: tb/sim_fcr_ratio_detect.sv
module sim_fcr_ratio_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [2:0] mult_code;
    logic       code_valid;
    logic       ratio_err;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    fcr_ratio_detect u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .mult_code(mult_code), .code_valid(code_valid), .ratio_err(ratio_err)
    );

    int ratios [8] = '{32, 64, 96, 128, 192, 256, 512, 1024};

    function automatic int code_for(int p);
        for (int i = 0; i < 8; i++) if (ratios[i] == p) return i;
        return -1;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fsync = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic frame(int p, int hi);
        for (int i = 0; i < p; i++) begin
            fsync = (i < hi);
            @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        fsync = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Three equal frames, then compare against arithmetic expectation
    task automatic sweep_one(int p);
        int c;
        c = code_for(p);
        do_reset();
        repeat (3) frame(p, 1);
        if (c >= 0) begin
            chk("R2 code", mult_code, c);
            chk("R4 valid", code_valid, 1);
            chk("R7 err", ratio_err, 0);
        end else begin
            chk("R6 code", mult_code, 0);
            chk("R6 valid", code_valid, 0);
            chk("R6 err", ratio_err, 1);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 code", mult_code, 0);
        chk("R1 valid", code_valid, 0);
        chk("R1 err", ratio_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code after release", mult_code, 0);
        chk("R1 valid after release", code_valid, 0);
        chk("R1 err after release", ratio_err, 0);

        // R3: supported-length gap before first edge is not a period
        do_reset();
        idle(63);
        frame(64, 1);
        frame(64, 1);
        chk("R3 no lock after two edges", code_valid, 0);
        frame(64, 1);
        chk("R3 lock after third edge", code_valid, 1);
        chk("R3 code", mult_code, 1);

        // R4: alternating supported lengths never lock
        do_reset();
        for (int k = 0; k < 3; k++) begin
            frame(64, 1);
            frame(128, 1);
        end
        chk("R4 alternating no lock", code_valid, 0);
        chk("R4 alternating err", ratio_err, 0);
        frame(128, 1);
        frame(128, 1);
        chk("R4 lock after repeat", code_valid, 1);
        chk("R4 code", mult_code, 3);

        // R5: frames after lock change nothing
        repeat (3) frame(100, 1);
        repeat (3) frame(256, 1);
        chk("R5 valid held", code_valid, 1);
        chk("R5 code held", mult_code, 3);
        chk("R5 err held", ratio_err, 0);

        // R6 / R7: unsupported then supported
        do_reset();
        frame(50, 1);
        frame(50, 1);
        chk("R6 err set", ratio_err, 1);
        chk("R6 code zero", mult_code, 0);
        frame(96, 1);
        frame(96, 1);
        chk("R7 err cleared", ratio_err, 0);
        chk("R7 not yet valid", code_valid, 0);
        frame(96, 1);
        chk("R7 lock", code_valid, 1);
        chk("R7 code", mult_code, 2);

        // R8: wide fsync pulses count once
        do_reset();
        repeat (3) frame(192, 10);
        chk("R8 valid", code_valid, 1);
        chk("R8 code", mult_code, 4);

        // R9: period beyond counter range saturates, unsupported
        do_reset();
        repeat (3) frame(4500, 1);
        chk("R9 err", ratio_err, 1);
        chk("R9 valid", code_valid, 0);
        chk("R9 code", mult_code, 0);

        // R2 / R6: near-exhaustive sweep of short periods
        for (int p = 20; p <= 140; p++) sweep_one(p);
        // R2: every supported ratio and its neighbours
        for (int i = 0; i < 8; i++) begin
            sweep_one(ratios[i] - 1);
            sweep_one(ratios[i]);
            sweep_one(ratios[i] + 1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule